// File: doc/BRIEF.md
# Four-Lane Pixel Word Serializer

The block takes one 28-bit pixel word per pixel period and turns it into four serial data lanes plus a forwarded clock lane. It runs on a bit clock at seven times the pixel rate. The pixel clock arrives as an input sampled in the bit-clock domain. A strap selects which pixel-clock edge captures the parallel word. A captured word waits in a holding register and is loaded into the lane shifters at the next frame boundary, which occurs every seven bit clocks. The lanes then shift the word out most significant bit first, seven bits per lane per pixel period.

The forwarded clock lane repeats a fixed seven-bit pattern that is aligned with the first bit of each data frame. A narrow strap selects a three-lane, 21-bit mode and disables the fourth lane. An active-low power-down input drops every output enable at once. After power-down ends, the outputs stay disabled until a whole frame has been loaded, so a partial frame is never driven. Differential drivers and the clock multiplier are outside the block.

Top module: `lvds_lane_serializer`

## Requirements
- R1: With `rise_sel` = 1, the word on `pix_data` is captured at the first bit-clock edge where `pix_clk` is seen high after being seen low.
- R2: With `rise_sel` = 0, the word is captured at the first bit-clock edge where `pix_clk` is seen low after being seen high.
- R3: Frame boundaries fall every 7 bit clocks, and the first one is the 7th bit-clock edge after reset is released. From a boundary, lane k drives captured bits 7k+6 down to 7k, one bit per bit clock, most significant bit first.
- R4: While enabled, `fclk_out` carries 1,1,0,0,0,1,1 over the seven bit slots of each frame. Its first 1 coincides with the first data bit of the frame.
- R5: A boundary loads the word captured before that edge. A capture at the same edge as the boundary goes into the following frame.
- R6: While `pd_n` is 0, every `lane_oe` bit and `fclk_oe` are 0 and every serial output is 0, in the same cycle and regardless of the other inputs.
- R7: After `pd_n` returns to 1, the enables stay 0 until the next frame boundary and rise together with the first bit of that frame.
- R8: While `narrow` is 1, `lane_oe[3]` and `lane_out[3]` are 0. Lanes 0 to 2 and the clock lane are not affected.
- R9: During reset, all enables and serial outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, sampled on clk_bit |
| rise_sel | input | 1 | Capture edge strap: 1 selects rising, 0 selects falling |
| pd_n | input | 1 | Active-low power-down |
| narrow | input | 1 | 1 selects three-lane, 21-bit mode |
| pix_data | input | 28 | Parallel pixel word |
| lane_out | output | 4 | Serial data lane bits |
| lane_oe | output | 4 | Per-lane output enables |
| fclk_out | output | 1 | Forwarded clock lane bit |
| fclk_oe | output | 1 | Forwarded clock lane enable |

## Verification
The bench changes the parallel word twice per pixel period, once between the rising and falling pixel edges and once after the falling edge. A design that captures on the wrong edge therefore serializes a different word. Power-down is released in the middle of a frame, where a design that enables at once would drive the tail end of an old frame. The bench also drives power-down and narrow mode while the data keeps toggling, to catch a fourth lane or clock lane that leaks. It shifts the pixel phase so that captures land on the same edge as frame loads, which catches a holding register that hands the new word to the current frame.

// File: rtl/lvds_lane_serializer.sv
module lvds_lane_serializer #(
  parameter int LANES = 4,
  parameter logic [6:0] CLK_PAT = 7'b1100011
) (
  input  logic                     clk_bit,
  input  logic                     rst_n,
  input  logic                     pix_clk,
  input  logic                     rise_sel,
  input  logic                     pd_n,
  input  logic                     narrow,
  input  logic [LANES*7-1:0]       pix_data,
  output logic [LANES-1:0]         lane_out,
  output logic [LANES-1:0]         lane_oe,
  output logic                     fclk_out,
  output logic                     fclk_oe
);
  localparam int FRAME = 7;
  localparam int WIDTH = LANES * FRAME;
  localparam int PW    = $clog2(FRAME);

  logic                           pix_q;
  logic [WIDTH-1:0]               hold;
  logic [LANES-1:0][FRAME-1:0]    sr;
  logic [PW-1:0]                  ph;
  logic                           en;

  wire load = (ph == PW'(FRAME - 1));
  wire cap  = rise_sel ? (pix_clk & ~pix_q) : (~pix_clk & pix_q);
  wire run  = pd_n & en;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= 1'b0;
      hold  <= '0;
      ph    <= '0;
      en    <= 1'b0;
    end else begin
      pix_q <= pix_clk;
      if (cap) hold <= pix_data;
      ph <= load ? '0 : ph + PW'(1);
      if (!pd_n)     en <= 1'b0;
      else if (load) en <= 1'b1;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk_bit or negedge rst_n) begin
      if (!rst_n)    sr[k] <= '0;
      else if (load) sr[k] <= hold[k*FRAME +: FRAME];
      else           sr[k] <= {sr[k][FRAME-2:0], 1'b0};
    end
    assign lane_oe[k]  = run & ~(narrow && (k == LANES - 1));
    assign lane_out[k] = sr[k][FRAME-1] & lane_oe[k];
  end

  assign fclk_oe  = run;
  assign fclk_out = CLK_PAT[PW'(FRAME - 1) - ph] & run;
endmodule

// File: rtl/lane_ser_checker.sv
module lane_ser_checker #(
  parameter int LANES = 4
) (
  input logic             clk_bit,
  input logic             rst_n,
  input logic             pd_n,
  input logic             narrow,
  input logic [LANES-1:0] lane_out,
  input logic [LANES-1:0] lane_oe,
  input logic             fclk_out,
  input logic             fclk_oe,
  input logic [2:0]       ph,
  input logic             next0
);
  assert_pd_tristate_R6: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !pd_n |-> (lane_oe == '0 && lane_out == '0 && !fclk_oe && !fclk_out));

  assert_narrow_lane_R8: assert property (@(posedge clk_bit) disable iff (!rst_n)
    narrow |-> (!lane_oe[LANES-1] && !lane_out[LANES-1]));

  assert_enable_at_frame_R7: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $rose(fclk_oe) |-> (ph == 3'd0));

  assert_clk_rise_R4: assert property (@(posedge clk_bit) disable iff (!rst_n)
    ($rose(fclk_out) && $past(fclk_oe)) |-> (ph == 3'd5));

  assert_clk_fall_R4: assert property (@(posedge clk_bit) disable iff (!rst_n)
    ($fell(fclk_out) && fclk_oe) |-> (ph == 3'd2));

  assert_msb_shift_R3: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (lane_oe[0] && $past(lane_oe[0]) && ph != 3'd0) |-> (lane_out[0] == $past(next0)));
endmodule

bind lvds_lane_serializer lane_ser_checker #(.LANES(LANES)) u_chk (
  .clk_bit(clk_bit), .rst_n(rst_n), .pd_n(pd_n), .narrow(narrow),
  .lane_out(lane_out), .lane_oe(lane_oe), .fclk_out(fclk_out), .fclk_oe(fclk_oe),
  .ph(ph), .next0(sr[0][5])
);

// File: tb/sim_lvds_lane_serializer.sv
module sim_lvds_lane_serializer;
  logic clk_bit = 1'b0;
  logic rst_n = 1'b0;
  logic pix_clk = 1'b0;
  logic rise_sel = 1'b1;
  logic pd_n = 1'b1;
  logic narrow = 1'b0;
  logic [27:0] pix_data = '0;
  logic [3:0] lane_out, lane_oe;
  logic fclk_out, fclk_oe;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int pcnt = 0;

  lvds_lane_serializer u0 (
    .clk_bit(clk_bit), .rst_n(rst_n), .pix_clk(pix_clk), .rise_sel(rise_sel),
    .pd_n(pd_n), .narrow(narrow), .pix_data(pix_data), .lane_out(lane_out),
    .lane_oe(lane_oe), .fclk_out(fclk_out), .fclk_oe(fclk_oe)
  );

  always #5 clk_bit = ~clk_bit;

  // reference model state
  int          m_n = 0;
  int          m_slot = 0;
  logic [27:0] m_cur = '0;
  logic [27:0] m_hold = '0;
  logic        m_prev = 1'b0;
  logic        m_en = 1'b0;
  logic        m_load;

  always @(posedge clk_bit) begin
    if (!rst_n) begin
      m_n = 0; m_slot = 0; m_cur = '0; m_hold = '0; m_prev = 1'b0; m_en = 1'b0;
    end else begin
      m_load = (m_n == 6);
      m_n = m_load ? 0 : m_n + 1;
      if (m_load) begin m_cur = m_hold; m_slot = 0; end
      else if (m_slot < 6) m_slot = m_slot + 1;
      if (!pd_n) m_en = 1'b0;
      else if (m_load) m_en = 1'b1;
      if (rise_sel ? (pix_clk && !m_prev) : (!pix_clk && m_prev)) m_hold = pix_data;
      m_prev = pix_clk;
    end
    #2 compare();
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
    end
  endtask

  task automatic compare();
    logic       run;
    logic [3:0] e_oe, e_out;
    logic       e_ck;
    if (!rst_n) begin
      check("R9 reset enables", {3'b0, fclk_oe, lane_oe}, 8'h00);
      check("R9 reset outputs", {3'b0, fclk_out, lane_out}, 8'h00);
      return;
    end
    run = pd_n && m_en;
    e_oe = {run && !narrow, run, run, run};
    for (int k = 0; k < 4; k++)
      e_out[k] = e_oe[k] && m_cur[7*k + 6 - m_slot];
    e_ck = run && (m_slot <= 1 || m_slot >= 5);
    // R6, R7, R8: enables
    check(!pd_n ? "R6 power-down enables" : (narrow ? "R8 narrow enables" : "R7 enables"),
          {3'b0, fclk_oe, lane_oe}, {3'b0, run, e_oe});
    // R3, R5, with R1 or R2 selecting the captured word
    check(rise_sel ? "R1 R3 R5 lane data" : "R2 R3 R5 lane data",
          {4'b0, lane_out}, {4'b0, e_out});
    // R4
    check("R4 forwarded clock", {7'b0, fclk_out}, {7'b0, e_ck});
  endtask

  // pixel clock: high for 4 bit clocks, low for 3; data changes between edges
  always @(negedge clk_bit) begin
    cycles++;
    pcnt = (pcnt + 1) % 7;
    pix_clk <= (pcnt < 4);
    if (pcnt == 2 || pcnt == 6) pix_data <= 28'($urandom);
  end

  task automatic run_cycles(input int n);
    repeat (n) @(negedge clk_bit);
  endtask

  initial begin
    run_cycles(5);
    rst_n = 1'b1;
    run_cycles(100);
    rise_sel = 1'b0;            // R2
    run_cycles(100);
    pd_n = 1'b0;                // R6
    run_cycles(33);
    pd_n = 1'b1;                // R7, released mid-frame
    run_cycles(60);
    narrow = 1'b1;              // R8
    run_cycles(70);
    narrow = 1'b0;
    rise_sel = 1'b1;
    pcnt = 3;                   // shift pixel phase against frames (R5)
    run_cycles(80);
    pd_n = 1'b0;
    narrow = 1'b1;
    run_cycles(11);
    pd_n = 1'b1;
    run_cycles(50);
    narrow = 1'b0;
    pcnt = 5;
    run_cycles(60);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected done", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule